// File: doc/BRIEF.md
# Cache Maintenance Range Splitter

This block turns one cache maintenance request into the series of commands that a line- and range-capable maintenance port can execute. A request carries an operation (invalidate, clean or flush), a byte start address and an exclusive byte end address. The block answers with single-line commands and bounded range commands, then a barrier command that marks the end of the request. Commands leave one at a time over a valid/ready handshake. A one-cycle `done` pulse follows the accepted barrier.

Range commands always carry an inclusive end, which is the address of the last line they cover. The block cuts ranges so that no single command covers more than a fixed number of bytes or crosses a page. This bounds how long the port can stall on any one command. An invalidate must not destroy dirty data that shares a line with bytes outside the request. So a partly covered line at either edge is cleaned and invalidated by a single-line command, and only whole lines are invalidated by range.

A write-through override input states that the cache never holds dirty data, so no clean work is needed. The block samples it together with the request.

Top module: `maint_range_splitter`

## Requirements
- R1: `req_ready` is high only while the block is idle. It goes low in the cycle after a request is accepted and returns high only after the barrier command is accepted. While `cmd_valid` is high and `cmd_ready` is low, the command kind and both addresses hold steady.
- R2: Every request ends with a barrier command (`cmd_kind` 3). `done` is high for exactly the one cycle after the barrier is accepted.
- R3: A request whose start is not below its end issues only the barrier, whatever the operation.
- R4: For invalidate (`req_op` 0) with a start that is not line aligned, the first command is a single-line clean-and-invalidate (`cmd_kind` 0) on the line holding the start. The range work then begins at the next line boundary.
- R5: For invalidate with an end that is not line aligned, a single-line clean-and-invalidate is issued on the line holding the end, directly after any head command. The range work stops at that line. The tail command is skipped when it would repeat the head line.
- R6: For invalidate, the whole lines between the trimmed bounds are covered by range invalidates (`cmd_kind` 2), in ascending order and without gaps.
- R7: For clean (`req_op` 1) and flush (`req_op` 2), the start is rounded down and the end is rounded up to 32-byte line boundaries before the range is split.
- R8: No range command covers more than 1024 bytes.
- R9: No range command crosses a 4096-byte page boundary. Each chunk ends at the nearest of start plus 1024, the next page boundary and the request end.
- R10: Range commands carry line-aligned addresses, and their end field equals the chunk's exclusive end minus 32.
- R11: For flush, each chunk issues a range clean (`cmd_kind` 1) and then a range invalidate with the same bounds.
- R12: With `wt_override` high when the request is accepted, a clean issues only the barrier, and a flush issues only the range invalidates of its chunks. Changing `wt_override` after acceptance has no effect on that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and takes a request |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 flush |
| req_start | input | ADDR_W | First byte address |
| req_end | input | ADDR_W | Exclusive end byte address |
| wt_override | input | 1 | Cache is write-through: skip clean work |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Port accepts the command |
| cmd_kind | output | 2 | 0 line clean+invalidate, 1 range clean, 2 range invalidate, 3 barrier |
| cmd_addr | output | ADDR_W | Line address or range start |
| cmd_end | output | ADDR_W | Inclusive last line address (equals cmd_addr for line commands) |
| done | output | 1 | One-cycle pulse after the barrier is accepted |

## Verification
The splitter is exercised with several kinds of request:
- Aligned spans inside one page show basic chunking.
- Spans larger than 1024 bytes and spans that cross a page test the two caps on the chunk end, separately and together (one chunk hits both limits at once).
- Invalidates with unaligned heads, unaligned tails, both edges in one line, and an aligned start with a partial end show that the edge trimming is independent of the range work.
- Empty and reversed requests, write-through clean and flush requests, and a flip of the override after acceptance show that only the barrier or the invalidate half survives.
- Runs with a stalling port show that the command is held steady and that new requests stay locked out.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

    typedef enum logic [1:0] {
        OP_INV   = 2'd0,
        OP_CLEAN = 2'd1,
        OP_FLUSH = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        K_LINE_CI = 2'd0,
        K_RCLEAN  = 2'd1,
        K_RINV    = 2'd2,
        K_BARRIER = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_TAIL,
        ST_CLN,
        ST_INV,
        ST_BAR
    } state_e;

    typedef struct packed {
        logic do_cln;
        logic do_inv;
    } work_t;

    // Which range passes a request needs, given the override sampled with it.
    function automatic work_t work_of(op_e op, logic wt);
        work_t w;
        w.do_cln = (op != OP_INV) && !wt;
        w.do_inv = (op != OP_CLEAN);
        return w;
    endfunction

    // Entry state for the range section of a request (or the barrier).
    function automatic state_e body_state(logic body_left, work_t w);
        if (!body_left)  return ST_BAR;
        if (w.do_cln)    return ST_CLN;
        if (w.do_inv)    return ST_INV;
        return ST_BAR;
    endfunction

endpackage

// File: rtl/mrs_req_align.sv
module mrs_req_align #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [ADDR_W-1:0] e_addr,
    output logic [ADDR_W:0]   cur,
    output logic [ADDR_W:0]   lim,
    output logic              need_head,
    output logic              need_tail,
    output logic [ADDR_W-1:0] head_line,
    output logic [ADDR_W-1:0] tail_line
);
    localparam int LG = $clog2(LINE_BYTES);
    localparam logic [ADDR_W:0] LINE_X = (ADDR_W+1)'(LINE_BYTES);

    logic [ADDR_W:0] s_floor, e_floor, s_ceil, e_ceil;
    logic            s_part, e_part, nonempty, is_inv;

    always_comb begin
        s_part   = s_addr[LG-1:0] != '0;
        e_part   = e_addr[LG-1:0] != '0;
        s_floor  = {1'b0, s_addr[ADDR_W-1:LG], {LG{1'b0}}};
        e_floor  = {1'b0, e_addr[ADDR_W-1:LG], {LG{1'b0}}};
        s_ceil   = s_part ? s_floor + LINE_X : s_floor;
        e_ceil   = e_part ? e_floor + LINE_X : e_floor;
        nonempty = s_addr < e_addr;
        is_inv   = op == 2'd0;

        if (!nonempty) begin
            cur = '0;
            lim = '0;
        end else if (is_inv) begin
            cur = s_ceil;
            lim = e_floor;
        end else begin
            cur = s_floor;
            lim = e_ceil;
        end

        need_head = nonempty && is_inv && s_part;
        need_tail = nonempty && is_inv && e_part && !(s_part && (s_floor == e_floor));
        head_line = s_floor[ADDR_W-1:0];
        tail_line = e_floor[ADDR_W-1:0];
    end
endmodule

// File: rtl/mrs_chunk_calc.sv
module mrs_chunk_calc #(
    parameter int ADDR_W      = 32,
    parameter int CHUNK_BYTES = 1024,
    parameter int PAGE_BYTES  = 4096
) (
    input  logic [ADDR_W:0] cur,
    input  logic [ADDR_W:0] lim,
    output logic [ADDR_W:0] nxt
);
    localparam logic [ADDR_W:0] CHUNK_X = (ADDR_W+1)'(CHUNK_BYTES);
    localparam logic [ADDR_W:0] PAGE_M  = (ADDR_W+1)'(PAGE_BYTES - 1);

    logic [ADDR_W:0] by_size, by_page, pick;

    always_comb begin
        by_size = cur + CHUNK_X;
        by_page = (cur | PAGE_M) + 1'b1;
        pick    = (by_size < by_page) ? by_size : by_page;
        nxt     = (lim < pick) ? lim : pick;
    end
endmodule

// File: rtl/mrs_sequencer.sv
module mrs_sequencer
    import mrs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic              wt_override,
    input  logic [ADDR_W:0]   al_cur,
    input  logic [ADDR_W:0]   al_lim,
    input  logic              al_head,
    input  logic              al_tail,
    input  logic [ADDR_W-1:0] al_head_line,
    input  logic [ADDR_W-1:0] al_tail_line,
    input  logic [ADDR_W:0]   nxt,
    output logic [ADDR_W:0]   cur_q,
    output logic [ADDR_W:0]   lim_q,
    output logic              req_ready,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_kind,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [ADDR_W-1:0] cmd_end,
    output logic              done
);
    localparam logic [ADDR_W:0] LINE_X = (ADDR_W+1)'(LINE_BYTES);

    state_e            state_q, first_st;
    work_t             work_q, work_in;
    logic              tail_q, done_q, fire;
    logic [ADDR_W-1:0] head_line_q, tail_line_q;
    logic [ADDR_W:0]   last_x;

    always_comb begin
        work_in  = work_of(op_e'(req_op), wt_override);
        if (al_head)      first_st = ST_HEAD;
        else if (al_tail) first_st = ST_TAIL;
        else              first_st = body_state(al_cur < al_lim, work_in);
        fire     = cmd_valid && cmd_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            work_q      <= '0;
            tail_q      <= 1'b0;
            cur_q       <= '0;
            lim_q       <= '0;
            head_line_q <= '0;
            tail_line_q <= '0;
            done_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    work_q      <= work_in;
                    tail_q      <= al_tail;
                    cur_q       <= al_cur;
                    lim_q       <= al_lim;
                    head_line_q <= al_head_line;
                    tail_line_q <= al_tail_line;
                    state_q     <= first_st;
                end
                ST_HEAD: if (fire)
                    state_q <= tail_q ? ST_TAIL : body_state(cur_q < lim_q, work_q);
                ST_TAIL: if (fire)
                    state_q <= body_state(cur_q < lim_q, work_q);
                ST_CLN: if (fire) begin
                    if (work_q.do_inv) begin
                        state_q <= ST_INV;
                    end else begin
                        cur_q   <= nxt;
                        state_q <= body_state(nxt < lim_q, work_q);
                    end
                end
                ST_INV: if (fire) begin
                    cur_q   <= nxt;
                    state_q <= body_state(nxt < lim_q, work_q);
                end
                ST_BAR: if (fire) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        last_x    = nxt - LINE_X;
        req_ready = state_q == ST_IDLE;
        cmd_valid = state_q != ST_IDLE;
        done      = done_q;
        cmd_kind  = K_BARRIER;
        cmd_addr  = '0;
        cmd_end   = '0;
        unique case (state_q)
            ST_HEAD: begin
                cmd_kind = K_LINE_CI;
                cmd_addr = head_line_q;
                cmd_end  = head_line_q;
            end
            ST_TAIL: begin
                cmd_kind = K_LINE_CI;
                cmd_addr = tail_line_q;
                cmd_end  = tail_line_q;
            end
            ST_CLN, ST_INV: begin
                cmd_kind = (state_q == ST_CLN) ? K_RCLEAN : K_RINV;
                cmd_addr = cur_q[ADDR_W-1:0];
                cmd_end  = last_x[ADDR_W-1:0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/maint_range_splitter.sv
module maint_range_splitter #(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 32,
    parameter int CHUNK_BYTES = 1024,
    parameter int PAGE_BYTES  = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_end,
    input  logic              wt_override,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_kind,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [ADDR_W-1:0] cmd_end,
    output logic              done
);
    logic [ADDR_W:0]   al_cur, al_lim, cur_q, lim_q, nxt;
    logic              al_head, al_tail;
    logic [ADDR_W-1:0] al_head_line, al_tail_line;

    mrs_req_align #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_align (
        .op        (req_op),
        .s_addr    (req_start),
        .e_addr    (req_end),
        .cur       (al_cur),
        .lim       (al_lim),
        .need_head (al_head),
        .need_tail (al_tail),
        .head_line (al_head_line),
        .tail_line (al_tail_line)
    );

    mrs_chunk_calc #(.ADDR_W(ADDR_W), .CHUNK_BYTES(CHUNK_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_chunk (
        .cur (cur_q),
        .lim (lim_q),
        .nxt (nxt)
    );

    mrs_sequencer #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_op       (req_op),
        .wt_override  (wt_override),
        .al_cur       (al_cur),
        .al_lim       (al_lim),
        .al_head      (al_head),
        .al_tail      (al_tail),
        .al_head_line (al_head_line),
        .al_tail_line (al_tail_line),
        .nxt          (nxt),
        .cur_q        (cur_q),
        .lim_q        (lim_q),
        .req_ready    (req_ready),
        .cmd_valid    (cmd_valid),
        .cmd_ready    (cmd_ready),
        .cmd_kind     (cmd_kind),
        .cmd_addr     (cmd_addr),
        .cmd_end      (cmd_end),
        .done         (done)
    );
endmodule

// File: rtl/mrs_checker.sv
module mrs_checker #(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 32,
    parameter int CHUNK_BYTES = 1024,
    parameter int PAGE_BYTES  = 4096
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [1:0]        cmd_kind,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [ADDR_W-1:0] cmd_end,
    input logic              done
);
    localparam int LINE_LG = $clog2(LINE_BYTES);
    localparam int PAGE_LG = $clog2(PAGE_BYTES);
    localparam logic [ADDR_W-1:0] SPAN_MAX = ADDR_W'(CHUNK_BYTES - LINE_BYTES);

    logic is_range;
    assign is_range = cmd_valid && (cmd_kind == 2'd1 || cmd_kind == 2'd2);

    // R1
    busy_lock_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !req_ready);

    // R1
    hold_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_kind)
                                       && $stable(cmd_addr) && $stable(cmd_end)));

    // R2
    done_follows_bar_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_kind == 2'd3) |=> (done && req_ready));

    // R2
    done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(cmd_valid && cmd_ready && cmd_kind == 2'd3));

    // R8
    chunk_cap_chk: assert property (@(posedge clk) disable iff (rst)
        is_range |-> (cmd_end >= cmd_addr && (cmd_end - cmd_addr) <= SPAN_MAX));

    // R9
    same_page_chk: assert property (@(posedge clk) disable iff (rst)
        is_range |-> (cmd_addr[ADDR_W-1:PAGE_LG] == cmd_end[ADDR_W-1:PAGE_LG]));

    // R10
    line_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_addr[LINE_LG-1:0] == '0 && cmd_end[LINE_LG-1:0] == '0));
endmodule

bind maint_range_splitter mrs_checker #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
    .CHUNK_BYTES(CHUNK_BYTES), .PAGE_BYTES(PAGE_BYTES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_kind  (cmd_kind),
    .cmd_addr  (cmd_addr),
    .cmd_end   (cmd_end),
    .done      (done)
);

// File: tb/tb_maint_range_splitter.sv
module tb_maint_range_splitter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = '0;
    logic [31:0] req_start = '0;
    logic [31:0] req_end = '0;
    logic        wt_override = 1'b0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [1:0]  cmd_kind;
    logic [31:0] cmd_addr;
    logic [31:0] cmd_end;
    logic        done;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    maint_range_splitter dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_start(req_start), .req_end(req_end),
        .wt_override(wt_override), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_end(cmd_end), .done(done)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] s;
        logic [31:0] e;
        logic        wt;
        logic [7:0]  n;
    } vec_t;

    // op: 0 inv, 1 clean, 2 flush; n counts commands including the barrier
    localparam vec_t VECS [13] = '{
        '{2'd0, 32'h1000, 32'h1100, 1'b0, 8'd2},  // R6 R10 aligned invalidate
        '{2'd0, 32'h1010, 32'h1130, 1'b0, 8'd4},  // R4 R5 R6 both edges partial
        '{2'd1, 32'h2000, 32'h2C00, 1'b0, 8'd4},  // R8 three 1024-byte cleans
        '{2'd2, 32'h2F00, 32'h3100, 1'b0, 8'd5},  // R9 R11 flush across a page
        '{2'd1, 32'h5005, 32'h5021, 1'b0, 8'd2},  // R7 rounding out
        '{2'd1, 32'h5000, 32'h6000, 1'b1, 8'd1},  // R12 clean under override
        '{2'd2, 32'h6000, 32'h6800, 1'b1, 8'd3},  // R12 flush under override
        '{2'd0, 32'h7008, 32'h7010, 1'b0, 8'd2},  // R5 head and tail share a line
        '{2'd0, 32'h7000, 32'h7000, 1'b0, 8'd1},  // R3 empty
        '{2'd2, 32'h8000, 32'h7000, 1'b0, 8'd1},  // R3 reversed
        '{2'd0, 32'h8C00, 32'h9A00, 1'b0, 8'd5},  // R8 R9 cap meets page
        '{2'd1, 32'h3E40, 32'h4100, 1'b0, 8'd3},  // R9 page cut before size cap
        '{2'd0, 32'h1000, 32'h101F, 1'b0, 8'd2}   // R5 aligned start, partial end
    };
    localparam string TAGS [13] = '{"R6", "R4 R5 R6", "R8", "R9 R11", "R7", "R12",
                                    "R12", "R5", "R3", "R3", "R8 R9", "R9", "R5"};

    int          en;
    logic [1:0]  ek [64];
    logic [31:0] ea [64];
    logic [31:0] ee [64];
    int          gn;
    logic [1:0]  gk [64];
    logic [31:0] ga [64];
    logic [31:0] ge [64];

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] k, input longint a, input longint e);
        ek[en] = k; ea[en] = a[31:0]; ee[en] = e[31:0]; en++;
    endtask

    // Expected command list, built from the requirements.
    task automatic build_exp(input logic [1:0] op, input longint s, input longint e,
                             input bit wt);
        longint cs, ce, nx, pg;
        en = 0;
        if (s < e) begin
            if (op == 2'd0) begin
                cs = s;
                if (s % 32 != 0) begin
                    push(2'd0, s - s % 32, s - s % 32);
                    cs = s - s % 32 + 32;
                end
                if (e % 32 != 0 && !(s % 32 != 0 && (s - s % 32) == (e - e % 32)))
                    push(2'd0, e - e % 32, e - e % 32);
                ce = e - e % 32;
            end else begin
                cs = s - s % 32;
                ce = (e % 32 != 0) ? e - e % 32 + 32 : e;
                if (op == 2'd1 && wt) ce = cs;
            end
            while (cs < ce) begin
                nx = cs + 1024;
                pg = (cs / 4096 + 1) * 4096;
                if (pg < nx) nx = pg;
                if (ce < nx) nx = ce;
                if (op != 2'd0 && !wt) push(2'd1, cs, nx - 32);
                if (op != 2'd1) push(2'd2, cs, nx - 32);
                cs = nx;
            end
        end
        push(2'd3, 0, 0);
    endtask

    // Offer a request, collect its commands, then check the done pulse.
    task automatic run_req(input logic [1:0] op, input logic [31:0] s, input logic [31:0] e,
                           input bit wt, input bit stall, input bit flip_wt,
                           input string tag);
        int   guard;
        bit   was_stalled, fin;
        logic [1:0]  pk;
        logic [31:0] pa, pe;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_start = s; req_end = e; wt_override = wt;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (flip_wt) wt_override = ~wt;
        check(req_ready == 1'b0, "R1", "req_ready low after accept", req_ready, 0);
        gn = 0; guard = 0; was_stalled = 0; fin = 0; pk = '0; pa = '0; pe = '0;
        while (!fin && guard < 5000) begin
            cmd_ready = stall ? ((guard % 3) == 2) : 1'b1;
            if (was_stalled)
                check(cmd_valid && cmd_kind == pk && cmd_addr == pa && cmd_end == pe,
                      "R1", "command held while stalled", {cmd_kind, cmd_addr}, {pk, pa});
            was_stalled = cmd_valid && !cmd_ready;
            pk = cmd_kind; pa = cmd_addr; pe = cmd_end;
            if (cmd_valid && cmd_ready) begin
                if (gn < 64) begin
                    gk[gn] = cmd_kind; ga[gn] = cmd_addr; ge[gn] = cmd_end;
                end
                gn++;
                if (cmd_kind == 2'd3) fin = 1;
            end else if (cmd_valid) begin
                check(req_ready == 1'b0, "R1", "req_ready low while busy", req_ready, 0);
            end
            guard++;
            @(posedge clk);
            @(negedge clk);
        end
        cmd_ready = 1'b0;
        check(fin, tag, "barrier reached", fin, 1);
        check(done == 1'b1, "R2", "done pulse after barrier", done, 1);
        check(req_ready == 1'b1, "R1", "ready again after barrier", req_ready, 1);
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b0, "R2", "done lasts one cycle", done, 0);
        build_exp(op, s, e, wt);
        check(gn == en, tag, "command count", gn, en);
        for (int i = 0; i < en && i < gn; i++) begin
            check(gk[i] == ek[i] && ga[i] == ea[i] && ge[i] == ee[i], tag,
                  $sformatf("command %0d kind/addr/end", i),
                  {gk[i], ga[i], ge[i]}, {ek[i], ea[i], ee[i]});
        end
    endtask

    initial begin
        repeat (2000 * 10) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 R2: reset state
        check(req_ready == 1'b1, "R1", "reset req_ready", req_ready, 1);
        check(cmd_valid == 1'b0, "R1", "reset cmd_valid", cmd_valid, 0);
        check(done == 1'b0, "R2", "reset done", done, 0);
        rst = 1'b0;

        for (int v = 0; v < 13; v++) begin
            build_exp(VECS[v].op, VECS[v].s, VECS[v].e, VECS[v].wt);
            check(en == int'(VECS[v].n), TAGS[v], "model count vs table", en, VECS[v].n);
            run_req(VECS[v].op, VECS[v].s, VECS[v].e, VECS[v].wt, 1'b0, 1'b0, TAGS[v]);
        end

        // R1: stalling port on a flush across a page and a split invalidate
        run_req(2'd2, 32'h2F00, 32'h3100, 1'b0, 1'b1, 1'b0, "R1 R11");
        run_req(2'd0, 32'h8C08, 32'h9A10, 1'b0, 1'b1, 1'b0, "R1 R4 R5 R6");

        // R12: override flipped after acceptance has no effect
        run_req(2'd2, 32'h6000, 32'h6800, 1'b1, 1'b0, 1'b1, "R12");
        run_req(2'd1, 32'h5000, 32'h5400, 1'b0, 1'b0, 1'b1, "R12");

        // R1: request held while busy is taken only after the barrier
        @(negedge clk);
        cmd_ready = 1'b0;
        req_valid = 1'b1; req_op = 2'd1; req_start = 32'h0; req_end = 32'h40; wt_override = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(cmd_valid && cmd_kind == 2'd1, "R1", "first command of held request",
              cmd_kind, 1);
        @(posedge clk);
        @(negedge clk);
        check(req_ready == 1'b0, "R1", "second request locked out", req_ready, 0);
        req_valid = 1'b0;
        cmd_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(cmd_kind == 2'd3, "R2", "barrier after single clean", cmd_kind, 3);
        @(posedge clk);
        @(negedge clk);
        cmd_ready = 1'b0;
        check(done && req_ready, "R2", "done after held request", done, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule